// File: doc/BRIEF.md
# Conditional Branch Resolver for a Bitstream Parser

This unit decides whether a parsing program follows a conditional branch. A branch request names up to two conditions. Each condition compares one operand with its own immediate value. The two results are joined by a logical operator, and the unit hands a single decision plus the request's target address to the address generator. The generator takes the target when the condition is false and falls through when it is true.

The operands come from one of two sources. In the memory variant, the operands are symbols decoded earlier. They are read from data memory at the addresses given in the request, on a fixed per-cycle schedule. In the register variant, the operand values travel inside the request itself, so no memory read is made. A busy flag gates new requests. A new request may be accepted in the cycle where the previous decision is presented, so branches can issue back to back.

Top module: `cond_branch_eval`

## Requirements
- R1: A request is accepted at a rising edge where reqValid is 1 and busy is 0. busy is 1 in every cycle after acceptance up to, but not including, the cycle in which decValid is 1. busy is 0 in that decision cycle.
- R2: Memory variant with two conditions: memRdEn is 1 with memRdAddr = first address in cycle 1 after acceptance, and with memRdAddr = second address in cycle 2. decValid is 1 in cycle 4. memRdData is taken to hold the word addressed one cycle earlier.
- R3: Memory variant with one condition: exactly one read, at the first address in cycle 1. decValid is 1 in cycle 3.
- R4: Register variant (reqFromMem = 0): memRdEn stays 0 for the whole operation, and decValid is 1 in cycle 2.
- R5: Each condition is evaluated as "operand OP immediate" on unsigned values. The comparison code is 00 equal, 01 not-equal, 10 less-than, 11 greater-or-equal.
- R6: With two conditions, reqComb = 0 joins the results with AND, and reqComb = 1 joins them with OR. The joined value appears on decCond.
- R7: With one condition (reqTwoCond = 0), decCond is the first result alone. The second address, second operand, second immediate, second code and reqComb have no effect.
- R8: Every accepted request yields exactly one single-cycle decValid pulse, with decTarget equal to that request's target.
- R9: A request presented while busy is 1 is ignored. It issues no read, produces no decision, and leaves the decision of the operation in progress unchanged.
- R10: A request accepted in a decision cycle starts its own schedule in the very next cycle.
- R11: While reset is asserted, busy, decValid and memRdEn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Branch request present |
| reqFromMem | input | 1 | 1: operands read from data memory; 0: operands carried in the request |
| reqTwoCond | input | 1 | 1: two conditions; 0: first condition only |
| reqSrcA | input | ADDR_W | Data-memory address of the first operand |
| reqSrcB | input | ADDR_W | Data-memory address of the second operand |
| reqLitA | input | DATA_W | First operand value for the register variant |
| reqLitB | input | DATA_W | Second operand value for the register variant |
| reqImmA | input | DATA_W | Immediate for the first condition |
| reqImmB | input | DATA_W | Immediate for the second condition |
| reqCmpA | input | 2 | Comparison code of the first condition |
| reqCmpB | input | 2 | Comparison code of the second condition |
| reqComb | input | 1 | Combiner: 0 AND, 1 OR |
| reqTarget | input | TGT_W | Address used when the condition is false |
| busy | output | 1 | Request cannot be accepted this cycle |
| memRdEn | output | 1 | Data-memory read strobe |
| memRdAddr | output | ADDR_W | Data-memory read address |
| memRdData | input | DATA_W | Read word, one cycle after memRdEn |
| decValid | output | 1 | Decision pulse |
| decCond | output | 1 | Combined condition result |
| decTarget | output | TGT_W | Target of the decided request |

## Verification
Two events can fall in the same cycle. One is the decision pulse of a finishing branch. The other is the acceptance of the next request, since busy drops in the decision cycle. The bench holds each new request from the start of the previous operation, so acceptance always lands on the decision cycle. A per-cycle reference model then judges two things: that the old decCond and decTarget are still intact in that cycle, and that the new read schedule begins in the following cycle. A separate case raises a request with different fields while busy is high. The model confirms that it causes no extra read or pulse and does not disturb the pending result.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_LT = 2'b10,
    CMP_GE = 2'b11
  } cmpOp_e;

  // strobes from the sequencer to the operand / compare datapath
  typedef struct packed {
    logic load;     // capture request fields
    logic rdB;      // second memory read this cycle (address select)
    logic rdA;      // first memory read this cycle
    logic evalA;    // compare first operand from read data
    logic evalB;    // compare second operand from read data
    logic evalLit;  // compare both operands carried in the request
  } dpStrobe_t;

endpackage

// File: rtl/bcu_dpath.sv
module bcu_dpath
  import bcu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int TGT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqTwoCond,
  input  logic [ADDR_W-1:0] reqSrcA,
  input  logic [ADDR_W-1:0] reqSrcB,
  input  logic [DATA_W-1:0] reqLitA,
  input  logic [DATA_W-1:0] reqLitB,
  input  logic [DATA_W-1:0] reqImmA,
  input  logic [DATA_W-1:0] reqImmB,
  input  logic [1:0]        reqCmpA,
  input  logic [1:0]        reqCmpB,
  input  logic              reqComb,
  input  logic [TGT_W-1:0]  reqTarget,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              decCond,
  output logic [TGT_W-1:0]  decTarget
);

  logic [ADDR_W-1:0] srcAQ, srcBQ;
  logic [DATA_W-1:0] litAQ, litBQ, immAQ, immBQ;
  cmpOp_e            cmpAQ, cmpBQ;
  logic              combQ, twoQ;
  logic [TGT_W-1:0]  tgtQ;
  logic              resAQ, resBQ;

  function automatic logic relate(input cmpOp_e op,
                                  input logic [DATA_W-1:0] lhs,
                                  input logic [DATA_W-1:0] rhs);
    logic r;
    case (op)
      CMP_EQ:  r = (lhs == rhs);
      CMP_NE:  r = (lhs != rhs);
      CMP_LT:  r = (lhs <  rhs);
      default: r = (lhs >= rhs);
    endcase
    return r;
  endfunction

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAQ <= '0;
      srcBQ <= '0;
      litAQ <= '0;
      litBQ <= '0;
      immAQ <= '0;
      immBQ <= '0;
      cmpAQ <= CMP_EQ;
      cmpBQ <= CMP_EQ;
      combQ <= 1'b0;
      twoQ  <= 1'b0;
      tgtQ  <= '0;
    end else if (strobe.load) begin
      srcAQ <= reqSrcA;
      srcBQ <= reqSrcB;
      litAQ <= reqLitA;
      litBQ <= reqLitB;
      immAQ <= reqImmA;
      immBQ <= reqImmB;
      cmpAQ <= cmpOp_e'(reqCmpA);
      cmpBQ <= cmpOp_e'(reqCmpB);
      combQ <= reqComb;
      twoQ  <= reqTwoCond;
      tgtQ  <= reqTarget;
    end
  end

  // individual condition results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAQ <= 1'b0;
      resBQ <= 1'b0;
    end else begin
      if (strobe.evalLit) begin
        resAQ <= relate(cmpAQ, litAQ, immAQ);
        resBQ <= relate(cmpBQ, litBQ, immBQ);
      end else begin
        if (strobe.evalA) resAQ <= relate(cmpAQ, memRdData, immAQ);
        if (strobe.evalB) resBQ <= relate(cmpBQ, memRdData, immBQ);
      end
    end
  end

  assign memRdAddr = strobe.rdB ? srcBQ : srcAQ;

  always_comb begin
    if (!twoQ)      decCond = resAQ;
    else if (combQ) decCond = resAQ | resBQ;
    else            decCond = resAQ & resBQ;
  end

  assign decTarget = tgtQ;

  // R2: a compare on read data always follows the matching read by one cycle
  p_evala_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalA |-> $past(strobe.rdA));
  p_evalb_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalB |-> $past(strobe.rdB));
  // R4: the register variant never evaluates in a read cycle
  p_lit_no_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalLit |-> !(strobe.rdA || strobe.rdB));

endmodule

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqFromMem,
  input  logic      reqTwoCond,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      memRdEn,
  output logic      decValid
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,    // cycle 1: read first operand
    ST_RDB,    // cycle 2: read second operand, compare first
    ST_CMPA,   // cycle 2: compare sole operand
    ST_CMPB,   // cycle 3: compare second operand
    ST_LIT,    // cycle 1: compare carried operands
    ST_DONE    // decision cycle
  } state_e;

  state_e stateQ, stateD;
  logic   twoQ;
  logic   accept;

  assign busy   = !(stateQ == ST_IDLE || stateQ == ST_DONE);
  assign accept = reqValid && !busy;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_RDA:  stateD = twoQ ? ST_RDB : ST_CMPA;
      ST_RDB:  stateD = ST_CMPB;
      ST_CMPA: stateD = ST_DONE;
      ST_CMPB: stateD = ST_DONE;
      ST_LIT:  stateD = ST_DONE;
      default: stateD = ST_IDLE;
    endcase
    if (accept) stateD = reqFromMem ? ST_RDA : ST_LIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      twoQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) twoQ <= reqTwoCond;
    end
  end

  always_comb begin
    strobe.load    = accept;
    strobe.rdA     = (stateQ == ST_RDA);
    strobe.rdB     = (stateQ == ST_RDB);
    strobe.evalA   = (stateQ == ST_RDB) || (stateQ == ST_CMPA);
    strobe.evalB   = (stateQ == ST_CMPB);
    strobe.evalLit = (stateQ == ST_LIT);
  end

  assign memRdEn  = strobe.rdA || strobe.rdB;
  assign decValid = (stateQ == ST_DONE);

  // R1: an accepted request raises busy in the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);
  // R8: the decision is a single-cycle pulse
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);
  // R2: reads only happen inside an operation
  p_read_in_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);
  // R3: a read is never immediately followed by the decision
  p_read_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !decValid);
  // R9: a request seen while busy does not restart the schedule
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && stateQ == ST_RDB) |=> stateQ == ST_CMPB);

endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import bcu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int TGT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqFromMem,
  input  logic              reqTwoCond,
  input  logic [ADDR_W-1:0] reqSrcA,
  input  logic [ADDR_W-1:0] reqSrcB,
  input  logic [DATA_W-1:0] reqLitA,
  input  logic [DATA_W-1:0] reqLitB,
  input  logic [DATA_W-1:0] reqImmA,
  input  logic [DATA_W-1:0] reqImmB,
  input  logic [1:0]        reqCmpA,
  input  logic [1:0]        reqCmpB,
  input  logic              reqComb,
  input  logic [TGT_W-1:0]  reqTarget,
  output logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              decValid,
  output logic              decCond,
  output logic [TGT_W-1:0]  decTarget
);

  dpStrobe_t strobe;

  bcu_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqFromMem (reqFromMem),
    .reqTwoCond (reqTwoCond),
    .strobe     (strobe),
    .busy       (busy),
    .memRdEn    (memRdEn),
    .decValid   (decValid)
  );

  bcu_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .TGT_W  (TGT_W)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqTwoCond (reqTwoCond),
    .reqSrcA    (reqSrcA),
    .reqSrcB    (reqSrcB),
    .reqLitA    (reqLitA),
    .reqLitB    (reqLitB),
    .reqImmA    (reqImmA),
    .reqImmB    (reqImmB),
    .reqCmpA    (reqCmpA),
    .reqCmpB    (reqCmpB),
    .reqComb    (reqComb),
    .reqTarget  (reqTarget),
    .memRdData  (memRdData),
    .memRdAddr  (memRdAddr),
    .decCond    (decCond),
    .decTarget  (decTarget)
  );

  // R11: nothing is active while reset is held
  always_comb begin
    if (!rstN) p_reset_quiet_r11: assert (!busy && !decValid && !memRdEn);
  end

endmodule

// File: tb/test_cond_branch_eval.sv
`timescale 1ns/1ps
module test_cond_branch_eval;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqFromMem = 1'b0, reqTwoCond = 1'b0, reqComb = 1'b0;
  logic [5:0]  reqSrcA = '0, reqSrcB = '0;
  logic [15:0] reqLitA = '0, reqLitB = '0, reqImmA = '0, reqImmB = '0;
  logic [1:0]  reqCmpA = '0, reqCmpB = '0;
  logic [9:0]  reqTarget = '0;
  logic        busy, memRdEn, decValid, decCond;
  logic [5:0]  memRdAddr;
  logic [15:0] memRdData = '0;
  logic [9:0]  decTarget;

  logic [15:0] memArr [64];

  int vectors = 0, errs = 0, cycles = 0;

  // reference model state
  int          k = 0, d = 0;
  bit          mMem = 0, mTwo = 0, mCond = 0;
  logic [5:0]  mA = '0, mB = '0;
  logic [9:0]  mTgt = '0;

  always #2 clk = ~clk;

  cond_branch_eval i_cond_branch_eval (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFromMem(reqFromMem),
    .reqTwoCond(reqTwoCond), .reqSrcA(reqSrcA), .reqSrcB(reqSrcB),
    .reqLitA(reqLitA), .reqLitB(reqLitB), .reqImmA(reqImmA), .reqImmB(reqImmB),
    .reqCmpA(reqCmpA), .reqCmpB(reqCmpB), .reqComb(reqComb), .reqTarget(reqTarget),
    .busy(busy), .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .decValid(decValid), .decCond(decCond), .decTarget(decTarget)
  );

  // data memory with one cycle of read latency
  always @(posedge clk) if (memRdEn) memRdData <= memArr[memRdAddr];

  function automatic bit refCmp(input int op, input int a, input int b);
    if (op == 0) return a == b;
    if (op == 1) return a != b;
    if (op == 2) return a < b;
    return a >= b;
  endfunction

  task automatic miss(input string req, input string what, input int got, input int exp);
    errs++;
    $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cycles, got, exp);
  endtask

  // compare on every clock, then step the model using the inputs held for the next edge
  always @(negedge clk) begin
    bit eBusy, eValid, eRd;
    logic [5:0] eAddr;
    eBusy  = (k > 0) && (k < d);
    eValid = (k > 0) && (k == d);
    eRd    = mMem && ((k == 1) || (mTwo && k == 2));
    eAddr  = (k == 2) ? mB : mA;
    vectors++;
    if (busy !== eBusy)     miss(rstN ? "R1" : "R11", "busy", busy, eBusy);
    if (decValid !== eValid) miss(rstN ? "R8" : "R11", "decValid", decValid, eValid);
    if (memRdEn !== eRd)    miss(rstN ? (mMem ? "R2" : "R4") : "R11", "memRdEn", memRdEn, eRd);
    if (eRd && memRdAddr !== eAddr) miss(mTwo ? "R2" : "R3", "memRdAddr", memRdAddr, eAddr);
    if (eValid && decCond !== mCond) miss(mTwo ? "R6" : "R7", "decCond", decCond, mCond);
    if (eValid && decTarget !== mTgt) miss("R8", "decTarget", decTarget, mTgt);
    if (!rstN) k = 0;
    else if (reqValid && !eBusy) begin
      int opA, opB;
      bit rA, rB;
      mMem = reqFromMem; mTwo = reqTwoCond; mA = reqSrcA; mB = reqSrcB; mTgt = reqTarget;
      opA = mMem ? int'(memArr[reqSrcA]) : int'(reqLitA);
      opB = mMem ? int'(memArr[reqSrcB]) : int'(reqLitB);
      rA = refCmp(int'(reqCmpA), opA, int'(reqImmA));
      rB = refCmp(int'(reqCmpB), opB, int'(reqImmB));
      mCond = !mTwo ? rA : (reqComb ? (rA | rB) : (rA & rB));
      d = !mMem ? 2 : (mTwo ? 4 : 3);
      k = 1;
    end else if (k > 0 && k < d) k++;
    else k = 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errs++;
      $display("FAIL R8 watchdog expired: got %0d expected %0d", cycles, 5000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic setFields(input bit fm, tw, input logic [5:0] sa, sb,
                           input logic [15:0] la, lb, ia, ib,
                           input logic [1:0] ca, cb, input bit cm, input logic [9:0] tg);
    reqFromMem = fm; reqTwoCond = tw; reqSrcA = sa; reqSrcB = sb;
    reqLitA = la; reqLitB = lb; reqImmA = ia; reqImmB = ib;
    reqCmpA = ca; reqCmpB = cb; reqComb = cm; reqTarget = tg;
  endtask

  task automatic sendReq(input bit fm, tw, input logic [5:0] sa, sb,
                         input logic [15:0] la, lb, ia, ib,
                         input logic [1:0] ca, cb, input bit cm, input logic [9:0] tg);
    @(posedge clk); #1;
    setFields(fm, tw, sa, sb, la, lb, ia, ib, ca, cb, cm, tg);
    reqValid = 1'b1;
    do @(negedge clk); while (busy);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) memArr[i] = 16'(i * 1013 + 7);
    memArr[0]  = 16'h0000;
    memArr[63] = 16'hFFFF;
    memArr[5]  = 16'h0001;
    memArr[6]  = 16'h0001;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;   // R11 checked by the model during the reset cycles

    // R2 R5 R6: two memory conditions, AND, both equal -> true
    sendReq(1, 1, 6'd5, 6'd6, 0, 0, 16'd1, 16'd1, 2'b00, 2'b00, 0, 10'd100);
    // R6: AND with second false; back-to-back acceptance (R10)
    sendReq(1, 1, 6'd5, 6'd6, 0, 0, 16'd1, 16'd2, 2'b00, 2'b00, 0, 10'd101);
    // R6: OR with one true
    sendReq(1, 1, 6'd5, 6'd6, 0, 0, 16'd3, 16'd1, 2'b00, 2'b00, 1, 10'd102);
    // R6 R5: OR with both false (NE on equal values)
    sendReq(1, 1, 6'd5, 6'd6, 0, 0, 16'd1, 16'd1, 2'b01, 2'b01, 1, 10'd103);
    // R3 R7: one condition, LT; second fields set so they would flip an AND
    sendReq(1, 0, 6'd0, 6'd63, 0, 0, 16'd1, 16'd0, 2'b10, 2'b00, 0, 10'd104);
    // R3 R5: GE boundary, all-ones operand equals immediate -> true
    sendReq(1, 0, 6'd63, 6'd0, 0, 0, 16'hFFFF, 16'd9, 2'b11, 2'b01, 1, 10'd105);
    // R5: LT boundary, all-ones not below all-ones -> false
    sendReq(1, 1, 6'd63, 6'd10, 0, 0, 16'hFFFF, 16'd0, 2'b10, 2'b11, 1, 10'd106);
    // R9: request with other fields raised while busy, then dropped
    @(posedge clk); #1;
    setFields(0, 0, 6'd1, 6'd2, 16'd7, 16'd7, 16'd7, 16'd7, 2'b00, 2'b00, 0, 10'd999);
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    // R4: register variant, NE and GE joined by AND
    sendReq(0, 1, 6'd3, 6'd4, 16'd10, 16'd20, 16'd11, 16'd20, 2'b01, 2'b11, 0, 10'd200);
    // R4 R5: register variant, LT at zero -> false
    sendReq(0, 1, 6'd0, 6'd0, 16'd0, 16'd5, 16'd0, 16'd5, 2'b10, 2'b00, 1, 10'd201);
    // R4 R7: register variant, one condition, second fields would make OR true
    sendReq(0, 0, 6'd0, 6'd0, 16'd4, 16'd9, 16'd5, 16'd9, 2'b11, 2'b00, 1, 10'd202);
    // R1: idle gap, then memory request followed straight by register request (R10)
    repeat (6) @(posedge clk);
    sendReq(1, 1, 6'd12, 6'd40, 0, 0, memArr[12], 16'd0, 2'b00, 2'b11, 0, 10'd300);
    sendReq(0, 1, 6'd0, 6'd0, 16'd8, 16'd8, 16'd9, 16'd8, 2'b10, 2'b01, 0, 10'd301);
    sendReq(1, 0, 6'd33, 6'd0, 0, 0, 16'd0, 16'd0, 2'b01, 2'b00, 0, 10'd1023);
    repeat (8) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule